// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block sits beside an SMBus/I2C controller. It watches the synchronized clock and data lines and the protocol event strobes that the controller already decodes. From these it keeps three timeout conditions. The first is a bus-free indication, raised when both lines have stayed high for a programmable number of cycles. The second is a master-side limit on how long this device may hold the clock low, summed over one byte. The third is a slave-side limit on the same stretching, summed over a whole message. Either extension violation also raises a combined low-timeout flag.

Every flag is sticky and is cleared by a one-cycle clear strobe. A bus-busy bit follows START and STOP. When the combined low-timeout flag is pending in master mode, an abort request rises at the next acknowledge boundary. The controller uses it to end the transfer with a STOP. Each limit is a cycle count, and a limit of zero turns its check off.

Top module: `smb_timeout_mon`

## Requirements
- R1: After reset, hi_flag, mext_flag, sext_flag, lo_flag, busy, hi_busy and abort_req are all 0.
- R2: hi_flag becomes 1 one edge after the hi_limit-th consecutive cycle in which scl_in and sda_in are both 1. A cycle with either line at 0 restarts the count. Once set and cleared, it does not set again during the same high period.
- R3: busy is set the edge after start_evt and cleared the edge after stop_evt. hi_busy equals busy AND hi_flag.
- R4: In master mode (master_mode=1), each cycle with scl_in=0 and self_stretch=1 adds one to a byte sum. Cycles that do not stretch leave the sum unchanged. mext_flag sets on the edge where the sum reaches mext_limit. The sum saturates and never wraps.
- R5: The byte sum is cleared by start_evt, ack_evt and stop_evt.
- R6: In slave mode (master_mode=0), stretching cycles add to a message sum. Only start_evt and stop_evt clear it; ack_evt does not. sext_flag sets on the edge where the sum reaches sext_limit.
- R7: lo_flag sets whenever mext_flag or sext_flag is set. Master stretching never sets sext_flag, and slave stretching never sets mext_flag.
- R8: A limit value of 0 disables the matching flag.
- R9: Each flag stays 1 until its clear strobe (clr_hi, clr_mext, clr_sext, clr_lo) is 1 for a cycle. A set and a clear in the same cycle leave the flag at 1.
- R10: abort_req becomes 1 the edge after an ack_evt seen with master_mode=1 and lo_flag=1. It returns to 0 the edge after stop_evt. An ack_evt with lo_flag=0 does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized clock line |
| sda_in | input | 1 | Synchronized data line |
| start_evt | input | 1 | START detected (one-cycle strobe) |
| stop_evt | input | 1 | STOP detected (one-cycle strobe) |
| ack_evt | input | 1 | Acknowledge boundary (one-cycle strobe) |
| master_mode | input | 1 | 1 = this device is master |
| self_stretch | input | 1 | This device is holding the clock low |
| hi_limit | input | LIM_W | Bus-free high-time limit in cycles; 0 disables |
| mext_limit | input | LIM_W | Per-byte master extension limit; 0 disables |
| sext_limit | input | LIM_W | Per-message slave extension limit; 0 disables |
| clr_hi | input | 1 | Clear strobe for hi_flag |
| clr_mext | input | 1 | Clear strobe for mext_flag |
| clr_sext | input | 1 | Clear strobe for sext_flag |
| clr_lo | input | 1 | Clear strobe for lo_flag |
| hi_flag | output | 1 | Bus-free high timeout |
| mext_flag | output | 1 | Master extension timeout |
| sext_flag | output | 1 | Slave extension timeout |
| lo_flag | output | 1 | Combined low timeout |
| busy | output | 1 | Bus busy between START and STOP |
| hi_busy | output | 1 | High timeout while busy (no STOP seen) |
| abort_req | output | 1 | Request to issue STOP at byte end |

## Verification
All flags, busy and abort_req are registered. Each one changes on the first clock edge after the cycle that carries its cause. The exception is hi_flag: it rises on the edge that closes the hi_limit-th consecutive high cycle, and the other flags likewise rise on the edge of the cycle in which the sum reaches its limit. The bench drives every input just after an edge, holds it for one full cycle, and samples outputs one time unit after the following edge. Each expected value therefore belongs to exactly the cycle listed in the vector table or the directed step.

// File: rtl/smb_mon_pkg.sv
// Shared constants for the SMBus timeout monitor: limit width and flag indices.
package smb_mon_pkg;
    localparam int LIMIT_W   = 16;
    localparam int NUM_FLAGS = 4;
    localparam int FL_HI     = 0;
    localparam int FL_MEXT   = 1;
    localparam int FL_SEXT   = 2;
    localparam int FL_LO     = 3;
endpackage

// File: rtl/smb_cycle_accum.sv
// Saturating cycle accumulator with a limit compare.
// Adds one on each cycle with 'count' set. Returns to zero on 'clear', which wins
// over counting. 'hit' is high for the single cycle in which the counted cycle
// brings the sum to 'limit'. Assumes limit==0 means disabled.
module smb_cycle_accum #(
    parameter int W = smb_mon_pkg::LIMIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] acc_q;
    logic         at_max;

    assign at_max = &acc_q;

    // Sum counted cycles; reset at boundaries; hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (clear)            acc_q <= '0;
        else if (count && !at_max) acc_q <= acc_q + ONE;
    end

    // Limit reached on this counted cycle.
    assign hit = count && !clear && (limit != '0) && (acc_q == limit - ONE);

    // R5 / R6: a boundary empties the sum
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));
    // R4: saturated sum never wraps
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clear) |=> at_max);
endmodule

// File: rtl/smb_sticky_flag.sv
// Sticky status bit: set by 'set', cleared by the one-cycle 'clr' strobe.
// Set wins when both arrive in the same cycle.
module smb_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until cleared; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R9: without a clear, the flag stays up
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
endmodule

// File: rtl/smb_timeout_mon.sv
// SMBus bus timeout monitor (top).
// Uses three accumulators: bus-free high time, per-byte master stretch and
// per-message slave stretch. Also keeps sticky flags, a busy bit and an abort
// request. Assumes scl_in/sda_in are already synchronized and the event strobes
// are one-cycle pulses from the controller.
module smb_timeout_mon #(
    parameter int LIM_W = smb_mon_pkg::LIMIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             ack_evt,
    input  logic             master_mode,
    input  logic             self_stretch,
    input  logic [LIM_W-1:0] hi_limit,
    input  logic [LIM_W-1:0] mext_limit,
    input  logic [LIM_W-1:0] sext_limit,
    input  logic             clr_hi,
    input  logic             clr_mext,
    input  logic             clr_sext,
    input  logic             clr_lo,
    output logic             hi_flag,
    output logic             mext_flag,
    output logic             sext_flag,
    output logic             lo_flag,
    output logic             busy,
    output logic             hi_busy,
    output logic             abort_req
);
    import smb_mon_pkg::*;

    logic lines_high, stretching;
    logic hi_hit, mext_hit, sext_hit;
    logic [NUM_FLAGS-1:0] f_set, f_clr, f_q;

    assign lines_high = scl_in && sda_in;
    assign stretching = !scl_in && self_stretch;

    smb_cycle_accum #(.W(LIM_W)) u_hi_acc (
        .clk(clk), .rst_n(rst_n),
        .count(lines_high), .clear(!lines_high),
        .limit(hi_limit), .hit(hi_hit));

    smb_cycle_accum #(.W(LIM_W)) u_mext_acc (
        .clk(clk), .rst_n(rst_n),
        .count(stretching && master_mode),
        .clear(start_evt || ack_evt || stop_evt),
        .limit(mext_limit), .hit(mext_hit));

    smb_cycle_accum #(.W(LIM_W)) u_sext_acc (
        .clk(clk), .rst_n(rst_n),
        .count(stretching && !master_mode),
        .clear(start_evt || stop_evt),
        .limit(sext_limit), .hit(sext_hit));

    // Route set and clear causes to each flag slot.
    always_comb begin
        f_set          = '0;
        f_clr          = '0;
        f_set[FL_HI]   = hi_hit;
        f_set[FL_MEXT] = mext_hit;
        f_set[FL_SEXT] = sext_hit;
        f_set[FL_LO]   = mext_hit || sext_hit;
        f_clr[FL_HI]   = clr_hi;
        f_clr[FL_MEXT] = clr_mext;
        f_clr[FL_SEXT] = clr_sext;
        f_clr[FL_LO]   = clr_lo;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        smb_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(f_set[i]), .clr(f_clr[i]), .q(f_q[i]));
    end

    assign hi_flag   = f_q[FL_HI];
    assign mext_flag = f_q[FL_MEXT];
    assign sext_flag = f_q[FL_SEXT];
    assign lo_flag   = f_q[FL_LO];

    // Bus occupancy between START and STOP; START wins on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_evt) busy <= 1'b1;
        else if (stop_evt)  busy <= 1'b0;
    end

    assign hi_busy = busy && hi_flag;

    // Ask for STOP at a byte boundary once a low timeout is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   abort_req <= 1'b0;
        else if (stop_evt)                            abort_req <= 1'b0;
        else if (ack_evt && master_mode && lo_flag)   abort_req <= 1'b1;
    end

    // R2: bus-free flag rises only after a high cycle
    a_r2_hi_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_flag) |-> $past(scl_in && sda_in));
    // R8: a zero high limit keeps the flag down
    a_r8_hi_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_limit == '0 && !hi_flag) |=> !hi_flag);
    // R3: START marks the bus busy
    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> busy);
    // R7: master extension only from master stretching
    a_r7_mext_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mext_flag) |-> $past(master_mode && self_stretch && !scl_in));
    // R7: slave extension only from slave stretching
    a_r7_sext_slave: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sext_flag) |-> $past(!master_mode && self_stretch && !scl_in));
    // R7: either extension flag rising brings the combined flag
    a_r7_lo_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mext_flag) || $rose(sext_flag)) |-> lo_flag);
    // R10: abort rises only from a master ACK boundary
    a_r10_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_req) |-> $past(ack_evt && master_mode));
endmodule

// File: tb/smb_timeout_mon_test.sv
module smb_timeout_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;
    // {scl, start, stop, ack, master, stretch, exp_busy, exp_mext, exp_lo}
    localparam logic [8:0] VEC [NV] = '{
        9'b1_1_0_0_1_0_1_0_0, // start
        9'b0_0_0_0_1_1_1_0_0, // stretch 1
        9'b0_0_0_0_1_1_1_0_0, // stretch 2
        9'b1_0_0_0_1_0_1_0_0, // scl high
        9'b0_0_0_0_1_0_1_0_0, // low, not ours
        9'b1_0_0_1_1_0_1_0_0, // ack clears
        9'b0_0_0_0_1_1_1_0_0, // 1
        9'b0_0_0_0_1_1_1_0_0, // 2
        9'b1_0_0_1_1_0_1_0_0, // ack clears
        9'b0_0_0_0_1_1_1_0_0, // 1
        9'b1_0_0_0_1_1_1_0_0, // scl high: no count
        9'b0_0_0_0_1_1_1_0_0, // 2
        9'b0_0_0_0_1_1_1_1_1, // 3 -> limit
        9'b0_0_0_0_1_1_1_1_1, // stays
        9'b1_0_1_0_1_0_0_1_1  // stop
    };

    logic clk = 0, rst_n = 0;
    logic scl = 1, sda = 0, st = 0, sp = 0, ak = 0, ms = 0, str = 0;
    logic [15:0] hl = 0, ml = 0, sl = 0;
    logic c_hi = 0, c_m = 0, c_s = 0, c_lo = 0;
    logic hi_f, m_f, s_f, lo_f, bsy, hib, abrt;
    int total = 0, bad = 0;

    smb_timeout_mon uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .start_evt(st), .stop_evt(sp), .ack_evt(ak), .master_mode(ms),
        .self_stretch(str), .hi_limit(hl), .mext_limit(ml), .sext_limit(sl),
        .clr_hi(c_hi), .clr_mext(c_m), .clr_sext(c_s), .clr_lo(c_lo),
        .hi_flag(hi_f), .mext_flag(m_f), .sext_flag(s_f), .lo_flag(lo_f),
        .busy(bsy), .hi_busy(hib), .abort_req(abrt));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // one cycle of line activity with strobes, strobes dropped afterwards
    task automatic cyc(input logic c, input logic d, input logic s_, input logic p_,
                       input logic a_, input logic x_);
        scl = c; sda = d; st = s_; sp = p_; ak = a_; str = x_;
        tick();
        st = 0; sp = 0; ak = 0;
    endtask

    task automatic clr_all();
        c_hi = 1; c_m = 1; c_s = 1; c_lo = 1; str = 0;
        tick();
        c_hi = 0; c_m = 0; c_s = 0; c_lo = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 hi", hi_f, 0); chk("R1 mext", m_f, 0); chk("R1 sext", s_f, 0);
        chk("R1 lo", lo_f, 0); chk("R1 busy", bsy, 0); chk("R1 hib", hib, 0);
        chk("R1 abort", abrt, 0);
        rst_n = 1;
        ml = 3;
        // R4 R5 R7 R3 table walk, master byte sums
        for (int i = 0; i < NV; i++) begin
            scl = VEC[i][8]; st = VEC[i][7]; sp = VEC[i][6]; ak = VEC[i][5];
            ms = VEC[i][4]; str = VEC[i][3];
            tick();
            chk("R3 busy (table)", bsy, VEC[i][2]);
            chk("R4/R5 mext (table)", m_f, VEC[i][1]);
            chk("R7 lo (table)", lo_f, VEC[i][0]);
            chk("R7 no sext from master", s_f, 0);
        end
        st = 0; sp = 0; ak = 0; str = 0;
        // R9 clear, then set wins over clear
        clr_all();
        chk("R9 mext cleared", m_f, 0); chk("R9 lo cleared", lo_f, 0);
        ml = 1;
        cyc(1, 0, 1, 0, 0, 0);
        c_m = 1; cyc(0, 0, 0, 0, 0, 1); c_m = 0;
        chk("R9 set wins", m_f, 1);
        c_m = 1; cyc(1, 0, 0, 0, 0, 0); c_m = 0;
        chk("R9 clr", m_f, 0);
        clr_all();
        // R2 high timeout, restart on a low line; busy from START above
        hl = 5;
        repeat (4) cyc(1, 1, 0, 0, 0, 0);
        chk("R2 not yet", hi_f, 0);
        cyc(1, 0, 0, 0, 0, 0);
        repeat (4) cyc(1, 1, 0, 0, 0, 0);
        chk("R2 restart", hi_f, 0);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R2 set", hi_f, 1);
        chk("R3 hi_busy", hib, 1);
        c_hi = 1; cyc(1, 1, 0, 0, 0, 0); c_hi = 0;
        repeat (3) cyc(1, 1, 0, 0, 0, 0);
        chk("R2 one-shot", hi_f, 0);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R3 stop", bsy, 0);
        // R8 zero limits
        hl = 0;
        repeat (10) cyc(1, 1, 0, 0, 0, 0);
        chk("R8 hi off", hi_f, 0);
        ml = 0; ms = 1;
        cyc(1, 0, 1, 0, 0, 0);
        repeat (5) cyc(0, 0, 0, 0, 0, 1);
        chk("R8 mext off", m_f, 0);
        cyc(1, 0, 0, 1, 0, 0);
        // R6 slave sum spans ACKs
        ms = 0; sl = 4; ml = 2;
        cyc(1, 0, 1, 0, 0, 0);
        repeat (2) cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R6 below", s_f, 0);
        chk("R7 no mext from slave", m_f, 0);
        cyc(1, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R6 sext", s_f, 1); chk("R7 lo", lo_f, 1);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R10 slave ack no abort", abrt, 0);
        cyc(1, 0, 0, 1, 0, 0);
        clr_all();
        // R6 START clears the message sum
        cyc(1, 0, 1, 0, 0, 0);
        repeat (3) cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        repeat (3) cyc(0, 0, 0, 0, 0, 1);
        chk("R6 start clears", s_f, 0);
        cyc(1, 0, 0, 1, 0, 0);
        // R10 abort request
        ms = 1; ml = 1;
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R10 no lo no abort", abrt, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R4 mext limit 1", m_f, 1);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R10 abort", abrt, 1);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R10 abort drops", abrt, 0);
        chk("R3 busy drops", bsy, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule